// File: doc/BRIEF.md
# Message-Signalled Interrupt Vector Table

This block keeps a table of interrupt messages for a PCI-style device, one entry per vector, together with a bit array of deferred requests. Software sees both through a 4 KB register window that accepts dword-sized accesses. Device logic raises a request by naming a vector. If that vector is open, the block emits a message write on a valid/ready output: a 64-bit target address and a 32-bit payload. If the vector is masked, the request is recorded in the deferred-bit array instead.

The block re-examines the table after every dword write. When a write leaves a vector unmasked while its deferred bit is set, the bit is cleared and the postponed message is sent. Each vector also has a small claim counter that device logic raises and lowers. Requests for vectors whose counter is zero are discarded. A global enable input gates all message traffic. Configuration-space decoding, BAR sizing and the bus transport are handled by the surrounding logic.

Top module: `msgvec_table`

## Requirements
- R1: Entry v occupies window offsets 16*v to 16*v+15. The word at +0 is the low address, +4 the high address, +8 the payload and +12 the control word. Bit 0 of the control word is the mask (1 = masked). A dword write to any of these words reads back unchanged.
- R2: Only the low 12 bits of `regAddr` select a location (the window repeats every 4096 bytes), and address bits 1:0 are ignored.
- R3: `regSize` encodes 0 = byte, 1 = halfword, 2 = dword and 3 = reserved. Any access whose size is not dword returns 0 on a read and changes nothing on a write.
- R4: The dword at offset 0x800 holds the deferred bits, with vector v in bit v. Writes to it are ignored. Offsets outside the NUM_VEC entries and outside that dword read 0 and ignore writes.
- R5: A request accepted for a claimed, unmasked vector produces exactly one message. The message address is {high word, low word} and the payload is the entry's payload word. `msgValid` rises on the clock after the request is accepted.
- R6: A request for a claimed, masked vector sets that vector's deferred bit and emits nothing.
- R7: A request is dropped with no message and no deferred bit when its vector index is NUM_VEC or higher, or when the vector's claim count is zero.
- R8: A claim pulse raises a vector's count and saturates at 2^USE_W-1. A release pulse lowers it and stops at 0. A claim and a release on the same cycle leave the count unchanged. Pulses naming a vector at NUM_VEC or above are ignored.
- R9: Once a vector is unmasked and its deferred bit is set, the bit is cleared and that vector's message is emitted. Deferred vectors are served before new requests, lowest index first. If the vector's count is zero at that moment, the bit is cleared and no message is sent.
- R10: `msgValid` stays high with a stable address and payload until `msgReady` is seen. Only one message is held at a time, and `reqReady` stays low while it is held.
- R11: While `enable` is low, requests are accepted and discarded with no message and no deferred bit, deferred vectors are left untouched, and the register window keeps working.
- R12: Reset clears every table word, every deferred bit and every claim count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Global message enable |
| regValid | input | 1 | Register access strobe |
| regWrite | input | 1 | 1 = write, 0 = read |
| regSize | input | 2 | Access size code (0 byte, 1 half, 2 dword, 3 reserved) |
| regAddr | input | ADDR_W | Byte address; only bits 11:2 are decoded |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational, valid in the access cycle |
| useClaim | input | 1 | Raise the claim count of `useVector` |
| useRelease | input | 1 | Lower the claim count of `useVector` |
| useVector | input | 5 | Vector addressed by claim/release |
| reqValid | input | 1 | Interrupt request |
| reqVector | input | 5 | Requested vector |
| reqReady | output | 1 | Request accepted on this cycle's edge when high |
| msgValid | output | 1 | Message available |
| msgAddr | output | 64 | Message target address |
| msgData | output | 32 | Message payload |
| msgReady | input | 1 | Message consumed on this cycle's edge when high |

## Verification
Requests are applied to vectors in every state: open and claimed, masked, unclaimed, out of range, and with the enable off. The message stream and the deferred dword together show whether a request was sent, deferred or dropped. A deferred pair that is released in one step, and then served only after the enable returns, separates the fixed lowest-index service order from arrival order. Claim counts are driven past saturation and below zero, and each subsequent request shows whether the counter clamped or wrapped. Narrow, aliased and unimplemented register accesses are compared with the table contents written through dword accesses.

// File: rtl/msgvec_pkg.sv
package msgvec_pkg;

  localparam int MAX_VEC   = 32;
  localparam int VEC_W     = 5;
  localparam int WIN_W     = 12;
  localparam logic [9:0] PEND_DW = 10'h200;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  typedef struct packed {
    logic             setPend;
    logic             clrPend;
    logic [VEC_W-1:0] pendVec;
  } dpStrobe_t;

  typedef struct packed {
    logic [63:0] addr;
    logic [31:0] data;
  } msgWord_t;

endpackage

// File: rtl/msgvec_datapath.sv
module msgvec_datapath
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int USE_W   = 2,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regSize,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              useClaim,
  input  logic              useRelease,
  input  logic [VEC_W-1:0]  useVector,
  input  dpStrobe_t         strobe,
  input  logic [VEC_W-1:0]  lkVec,
  output logic              lkMasked,
  output logic              lkUsed,
  output msgWord_t          lkMsg,
  output logic              flushAvail,
  output logic [VEC_W-1:0]  flushVec
);

  localparam logic [USE_W-1:0] USE_MAX = '1;

  logic [WIN_W-1:0]   winOff;
  logic [VEC_W-1:0]   entIdx;
  logic               isWord, tblHit, pendHit, wrEn, rdEn;
  logic               unusedBits;
  logic [127:0]       entryFlat [NUM_VEC];
  logic [NUM_VEC-1:0] maskVec, pendVec, usedVec, cand;
  logic [127:0]       rdEnt;

  assign winOff     = regAddr[WIN_W-1:0];
  assign unusedBits = ^{regAddr[ADDR_W-1:WIN_W], winOff[1:0]};
  assign entIdx     = winOff[8:4];
  assign isWord     = (regSize == SZ_WORD);
  assign tblHit     = (winOff[11:9] == 3'b000);
  assign pendHit    = (winOff[11:2] == PEND_DW);
  assign wrEn       = regValid && regWrite && isWord && tblHit;
  assign rdEn       = regValid && !regWrite && isWord;

  for (genvar v = 0; v < NUM_VEC; v++) begin : g_vec
    localparam logic [VEC_W-1:0] VID = VEC_W'(v);
    logic [31:0]      wordQ [4];
    logic             pendQ;
    logic [USE_W-1:0] cntQ;
    logic             claimHit, relHit;

    assign claimHit = useClaim && (useVector == VID);
    assign relHit   = useRelease && (useVector == VID);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int w = 0; w < 4; w++) wordQ[w] <= '0;
      end else if (wrEn && entIdx == VID) begin
        wordQ[winOff[3:2]] <= regWdata;
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       pendQ <= 1'b0;
      else if (strobe.clrPend && strobe.pendVec == VID) pendQ <= 1'b0;
      else if (strobe.setPend && strobe.pendVec == VID) pendQ <= 1'b1;
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cntQ <= '0;
      end else if (claimHit && !relHit) begin
        if (cntQ != USE_MAX) cntQ <= cntQ + 1'b1;
      end else if (relHit && !claimHit) begin
        if (cntQ != '0) cntQ <= cntQ - 1'b1;
      end
    end

    assign entryFlat[v] = {wordQ[3], wordQ[2], wordQ[1], wordQ[0]};
    assign maskVec[v]   = wordQ[3][0];
    assign pendVec[v]   = pendQ;
    assign usedVec[v]   = |cntQ;

    // R8: release at zero keeps zero
    p_use_floor_r8: assert property (@(posedge clk) disable iff (!rstN)
      (relHit && !claimHit && cntQ == '0) |=> (cntQ == '0));
    // R8: claim at maximum keeps maximum
    p_use_ceiling_r8: assert property (@(posedge clk) disable iff (!rstN)
      (claimHit && !relHit && cntQ == USE_MAX) |=> (cntQ == USE_MAX));
    // R3: narrow writes leave the entry untouched
    p_narrow_ignored_r3: assert property (@(posedge clk) disable iff (!rstN)
      (regValid && regWrite && regSize != SZ_WORD) |=> $stable(entryFlat[v]));
  end

  always_comb begin
    lkMasked = 1'b0;
    lkUsed   = 1'b0;
    lkMsg    = '0;
    rdEnt    = '0;
    for (int i = 0; i < NUM_VEC; i++) begin
      if (lkVec == VEC_W'(i)) begin
        lkMasked   = maskVec[i];
        lkUsed     = usedVec[i];
        lkMsg.addr = entryFlat[i][63:0];
        lkMsg.data = entryFlat[i][95:64];
      end
      if (entIdx == VEC_W'(i)) rdEnt = entryFlat[i];
    end
  end

  always_comb begin
    regRdata = '0;
    if (rdEn && tblHit) begin
      case (winOff[3:2])
        2'd0:    regRdata = rdEnt[31:0];
        2'd1:    regRdata = rdEnt[63:32];
        2'd2:    regRdata = rdEnt[95:64];
        default: regRdata = rdEnt[127:96];
      endcase
    end else if (rdEn && pendHit) begin
      regRdata = 32'(pendVec);
    end
  end

  assign cand       = pendVec & ~maskVec;
  assign flushAvail = |cand;

  always_comb begin
    flushVec = '0;
    for (int i = NUM_VEC - 1; i >= 0; i--) begin
      if (cand[i]) flushVec = VEC_W'(i);
    end
  end

  // R6: a deferred bit only appears on a vector that was masked
  p_pend_needs_mask_r6: assert property (@(posedge clk) disable iff (!rstN)
    ((pendVec & ~$past(pendVec) & ~$past(maskVec)) == '0));

endmodule

// File: rtl/msgvec_ctrl.sv
module msgvec_ctrl
  import msgvec_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             reqValid,
  input  logic [VEC_W-1:0] reqVector,
  output logic             reqReady,
  output logic             msgValid,
  output logic [63:0]      msgAddr,
  output logic [31:0]      msgData,
  input  logic             msgReady,
  output logic [VEC_W-1:0] lkVec,
  input  logic             lkMasked,
  input  logic             lkUsed,
  input  msgWord_t         lkMsg,
  input  logic             flushAvail,
  input  logic [VEC_W-1:0] flushVec,
  output dpStrobe_t        strobe
);

  logic     validQ;
  msgWord_t msgQ;
  logic     flushGo, reqFire, loadMsg;

  assign flushGo  = enable && flushAvail && !validQ;
  assign reqReady = !validQ && !(enable && flushAvail);
  assign reqFire  = reqValid && reqReady;
  assign lkVec    = flushGo ? flushVec : reqVector;

  always_comb begin
    strobe         = '0;
    strobe.pendVec = lkVec;
    loadMsg        = 1'b0;
    if (flushGo) begin
      strobe.clrPend = 1'b1;
      loadMsg        = lkUsed;
    end else if (reqFire && enable && lkUsed) begin
      if (lkMasked) strobe.setPend = 1'b1;
      else          loadMsg        = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      validQ <= 1'b0;
      msgQ   <= '0;
    end else if (loadMsg) begin
      validQ <= 1'b1;
      msgQ   <= lkMsg;
    end else if (validQ && msgReady) begin
      validQ <= 1'b0;
    end
  end

  assign msgValid = validQ;
  assign msgAddr  = msgQ.addr;
  assign msgData  = msgQ.data;

  // R10: held message stays put until consumed
  p_hold_until_taken_r10: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgAddr) && $stable(msgData)));
  // R11: nothing new appears while disabled
  p_quiet_when_off_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!enable && !msgValid) |=> !msgValid);
  // R5: accepted open request shows up with the entry payload
  p_emit_payload_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && enable && lkUsed && !lkMasked)
      |=> (msgValid && msgData == $past(lkMsg.data)));

endmodule

// File: rtl/msgvec_table.sv
module msgvec_table
  import msgvec_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int USE_W   = 2,
  parameter int ADDR_W  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              regValid,
  input  logic              regWrite,
  input  logic [1:0]        regSize,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              useClaim,
  input  logic              useRelease,
  input  logic [4:0]        useVector,
  input  logic              reqValid,
  input  logic [4:0]        reqVector,
  output logic              reqReady,
  output logic              msgValid,
  output logic [63:0]       msgAddr,
  output logic [31:0]       msgData,
  input  logic              msgReady
);

  dpStrobe_t        strobe;
  logic [VEC_W-1:0] lkVec, flushVec;
  logic             lkMasked, lkUsed, flushAvail;
  msgWord_t         lkMsg;

  msgvec_datapath #(
    .NUM_VEC (NUM_VEC),
    .USE_W   (USE_W),
    .ADDR_W  (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .regValid   (regValid),
    .regWrite   (regWrite),
    .regSize    (regSize),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .regRdata   (regRdata),
    .useClaim   (useClaim),
    .useRelease (useRelease),
    .useVector  (useVector),
    .strobe     (strobe),
    .lkVec      (lkVec),
    .lkMasked   (lkMasked),
    .lkUsed     (lkUsed),
    .lkMsg      (lkMsg),
    .flushAvail (flushAvail),
    .flushVec   (flushVec)
  );

  msgvec_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enable     (enable),
    .reqValid   (reqValid),
    .reqVector  (reqVector),
    .reqReady   (reqReady),
    .msgValid   (msgValid),
    .msgAddr    (msgAddr),
    .msgData    (msgData),
    .msgReady   (msgReady),
    .lkVec      (lkVec),
    .lkMasked   (lkMasked),
    .lkUsed     (lkUsed),
    .lkMsg      (lkMsg),
    .flushAvail (flushAvail),
    .flushVec   (flushVec),
    .strobe     (strobe)
  );

endmodule

// File: tb/msgvec_table_tb.sv
`timescale 1ns/1ps
module msgvec_table_tb;

  localparam int NV = 8;

  logic        clk = 1'b0;
  logic        rstN, enable, regValid, regWrite;
  logic [1:0]  regSize;
  logic [15:0] regAddr;
  logic [31:0] regWdata, regRdata;
  logic        useClaim, useRelease, reqValid, reqReady;
  logic [4:0]  useVector, reqVector;
  logic        msgValid, msgReady;
  logic [63:0] msgAddr;
  logic [31:0] msgData;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 0;

  logic [95:0] expQ [$];
  string       tagQ [$];

  always #10 clk = ~clk;

  msgvec_table #(.NUM_VEC(NV), .USE_W(2), .ADDR_W(16)) u_dut (
    .clk(clk), .rstN(rstN), .enable(enable),
    .regValid(regValid), .regWrite(regWrite), .regSize(regSize),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .useClaim(useClaim), .useRelease(useRelease), .useVector(useVector),
    .reqValid(reqValid), .reqVector(reqVector), .reqReady(reqReady),
    .msgValid(msgValid), .msgAddr(msgAddr), .msgData(msgData),
    .msgReady(msgReady)
  );

  task automatic check(input string tag, input logic [95:0] act, input logic [95:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  // monitor: compare each consumed message against the scoreboard
  always begin
    @(negedge clk);
    #5;
    if (msgValid && msgReady) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFail++;
        $display("FAIL R7 unexpected message act=%h exp=none", {msgAddr, msgData});
      end else begin
        logic [95:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, {msgAddr, msgData}, e);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL R10 watchdog act=hung exp=finished");
    finishRun();
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [1:0] sz = 2'd2);
    regValid = 1; regWrite = 1; regAddr = a; regWdata = d; regSize = sz;
    @(negedge clk);
    regValid = 0; regWrite = 0;
  endtask

  task automatic rdChk(input string tag, input logic [15:0] a, input logic [31:0] exp,
                       input logic [1:0] sz = 2'd2);
    regValid = 1; regWrite = 0; regAddr = a; regSize = sz;
    #2;
    check(tag, 96'(regRdata), 96'(exp));
    @(negedge clk);
    regValid = 0;
  endtask

  task automatic prog(input int v, input logic [31:0] lo, input logic [31:0] hi,
                      input logic [31:0] dat, input logic [31:0] ctl);
    wr(16'(v * 16),      lo);
    wr(16'(v * 16 + 4),  hi);
    wr(16'(v * 16 + 8),  dat);
    wr(16'(v * 16 + 12), ctl);
  endtask

  task automatic claim(input int v);
    useClaim = 1; useVector = 5'(v);
    @(negedge clk);
    useClaim = 0;
  endtask

  task automatic release_v(input int v);
    useRelease = 1; useVector = 5'(v);
    @(negedge clk);
    useRelease = 0;
  endtask

  task automatic request(input int v);
    reqValid = 1; reqVector = 5'(v);
    forever begin
      #1;
      if (reqReady) break;
      @(negedge clk);
    end
    @(negedge clk);
    reqValid = 0;
  endtask

  task automatic expect_msg(input logic [31:0] hi, input logic [31:0] lo,
                            input logic [31:0] dat, input string tag);
    expQ.push_back({hi, lo, dat});
    tagQ.push_back(tag);
  endtask

  task automatic drain(input string tag);
    repeat (10) @(negedge clk);
    check(tag, 96'(expQ.size()), 96'd0);
  endtask

  initial begin
    rstN = 0; enable = 1; regValid = 0; regWrite = 0; regSize = 2'd2;
    regAddr = '0; regWdata = '0; useClaim = 0; useRelease = 0; useVector = '0;
    reqValid = 0; reqVector = '0; msgReady = 1;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // reset state
    rdChk("R12 reset entry0 low", 16'h000, 32'h0);
    rdChk("R12 reset pending", 16'h800, 32'h0);
    check("R12 reset msgValid", 96'(msgValid), 96'd0);

    // table layout and read-back
    prog(0, 32'hFEE0_0000, 32'h0000_0001, 32'h0000_0041, 32'h0);
    prog(1, 32'hFEE0_1000, 32'h0,         32'h0000_0042, 32'h1);
    prog(2, 32'hFEE0_2000, 32'h0,         32'h0000_0044, 32'h0);
    prog(3, 32'hFEE0_3000, 32'h0000_0002, 32'h0000_0043, 32'h1);
    prog(4, 32'hFEE0_4000, 32'h0,         32'h0000_0045, 32'h0);
    rdChk("R1 entry0 low",  16'h000, 32'hFEE0_0000);
    rdChk("R1 entry0 high", 16'h004, 32'h0000_0001);
    rdChk("R1 entry0 data", 16'h008, 32'h0000_0041);
    rdChk("R1 entry3 ctrl", 16'h03C, 32'h1);

    // aliasing and alignment
    rdChk("R2 alias+misalign high", 16'h1005, 32'h0000_0001);
    rdChk("R2 alias data", 16'hF00B, 32'h0000_0041);

    // narrow accesses
    wr(16'h008, 32'hDEAD_BEEF, 2'd0);
    wr(16'h008, 32'hDEAD_BEEF, 2'd1);
    rdChk("R3 narrow write ignored", 16'h008, 32'h0000_0041);
    rdChk("R3 byte read zero", 16'h008, 32'h0, 2'd0);
    rdChk("R3 half read zero", 16'h000, 32'h0, 2'd1);
    rdChk("R3 reserved size zero", 16'h004, 32'h0, 2'd3);

    // pending dword and holes
    wr(16'h800, 32'hFFFF_FFFF);
    rdChk("R4 pending read-only", 16'h800, 32'h0);
    wr(16'h700, 32'h1234_5678);
    rdChk("R4 hole reads zero", 16'h700, 32'h0);
    wr(16'h090, 32'h1234_5678);
    rdChk("R4 entry beyond count zero", 16'h090, 32'h0);

    // drops: unclaimed and out of range
    request(0);
    claim(9);
    request(9);
    drain("R7 dropped requests");
    rdChk("R7 no pending from drops", 16'h800, 32'h0);

    // open vectors
    claim(0);
    expect_msg(32'h1, 32'hFEE0_0000, 32'h41, "R5 vector0 message");
    request(0);
    claim(2);
    expect_msg(32'h0, 32'hFEE0_2000, 32'h44, "R5 vector2 message");
    request(2);
    drain("R5 messages delivered");

    // masked request defers
    claim(1);
    request(1);
    rdChk("R6 pending bit1", 16'h800, 32'h2);
    drain("R6 no message while masked");

    // unmask flush
    expect_msg(32'h0, 32'hFEE0_1000, 32'h42, "R9 flush vector1");
    wr(16'h01C, 32'h0);
    drain("R9 flush delivered");
    rdChk("R9 pending cleared", 16'h800, 32'h0);

    // flush priority order, held by enable low
    claim(3);
    wr(16'h01C, 32'h1);
    request(3);
    request(1);
    rdChk("R6 pending bits 1 and 3", 16'h800, 32'h0A);
    enable = 0;
    wr(16'h03C, 32'h0);
    wr(16'h01C, 32'h0);
    drain("R11 flush held while disabled");
    rdChk("R11 pending kept while disabled", 16'h800, 32'h0A);
    expect_msg(32'h0, 32'hFEE0_1000, 32'h42, "R9 lowest index first");
    expect_msg(32'h2, 32'hFEE0_3000, 32'h43, "R9 then vector3");
    enable = 1;
    drain("R9 ordered flush");

    // unclaimed flush drops
    wr(16'h02C, 32'h1);
    request(2);
    rdChk("R6 pending bit2", 16'h800, 32'h4);
    release_v(2);
    wr(16'h02C, 32'h0);
    drain("R9 unclaimed flush silent");
    rdChk("R9 unclaimed pending cleared", 16'h800, 32'h0);

    // claim counter saturation and floor
    repeat (5) claim(4);
    release_v(4);
    release_v(4);
    expect_msg(32'h0, 32'hFEE0_4000, 32'h45, "R8 saturated count still claimed");
    request(4);
    drain("R8 saturation");
    release_v(4);
    request(4);
    drain("R8 count reached zero");
    release_v(4);
    claim(4);
    expect_msg(32'h0, 32'hFEE0_4000, 32'h45, "R8 floor at zero");
    request(4);
    drain("R8 floor");
    useClaim = 1; useRelease = 1; useVector = 5'd4;
    @(negedge clk);
    useClaim = 0; useRelease = 0;
    release_v(4);
    request(4);
    drain("R8 simultaneous claim and release");

    // handshake hold
    msgReady = 0;
    expect_msg(32'h1, 32'hFEE0_0000, 32'h41, "R10 held message");
    request(0);
    #1;
    check("R10 valid raised", 96'(msgValid), 96'd1);
    check("R10 ready low while held", 96'(reqReady), 96'd0);
    repeat (3) @(negedge clk);
    #1;
    check("R10 still valid", 96'(msgValid), 96'd1);
    check("R10 payload stable", {msgAddr, msgData}, {32'h1, 32'hFEE0_0000, 32'h41});
    @(negedge clk);
    msgReady = 1;
    drain("R10 released");

    // disabled
    enable = 0;
    request(0);
    wr(16'h00C, 32'h1);
    request(0);
    rdChk("R11 no pending while disabled", 16'h800, 32'h0);
    rdChk("R11 window readable", 16'h000, 32'hFEE0_0000);
    wr(16'h00C, 32'h0);
    enable = 1;
    drain("R11 no messages while disabled");

    // mid-run reset
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    @(negedge clk);
    rdChk("R12 table cleared", 16'h000, 32'h0);
    rdChk("R12 pending cleared", 16'h800, 32'h0);
    request(0);
    drain("R12 claims cleared");

    finishRun();
  end

endmodule